// File: doc/BRIEF.md
# Timestamped Transmit Packet Scheduler

This block reads fixed-size transmit packets from the head of a word queue and decides when each one may go out. The first word of a packet is the header and the second is the timestamp. The block holds the packet until a local sample counter reaches the timestamp. It discards the packet if that time has already passed. A timestamp of all ones means "send on the next sample tick". Once a data packet is released, its payload words go to the converter-side sample output, one per sample tick. The padding that fills the rest of the packet is read off the queue and thrown away.

The block also keeps track of whether a burst is in progress. A burst starts when a data packet is released. It ends once the last sample of a packet carrying the end-of-burst flag has gone out. A sample tick that carries no sample raises an underrun pulse only while a burst is in progress. Between bursts the sample output rests at zero. Packets on the reserved control channel obey the same timing rules. They produce no samples: their payload words go, in order, to a control-interpreter port.

Top module: `tsched_tx`

## Requirements
- R1: A packet is `PKT_WORDS` 32-bit words long. Word 0 is the header and word 1 is the timestamp. The header fields are: bit 28 start-of-burst, bit 27 end-of-burst, bits 20:16 channel, bits 8:0 payload length in bytes. The block pops every word of every packet exactly once.
- R2: A local time counter is 0 after reset and increases by one on every cycle where `samp_tick` is high. A data packet with an ordinary timestamp sends its first payload sample on the tick cycle where the counter equals the timestamp. The sample appears on `samp_data`/`samp_valid` in the following cycle.
- R3: A packet is late when its timestamp is not all ones and (counter − timestamp), taken as a signed 32-bit value, is above zero. This comparison is wrap-aware, so a timestamp 0x90000000 ahead of the counter counts as late. A late packet produces no samples, no control words and one single-cycle `drop_pulse`.
- R4: A timestamp of 0xFFFFFFFF releases the packet on the first sample tick after it reaches the head.
- R5: The number of payload samples is ceil(length/4), with length capped at (`PKT_WORDS`−2)·4 bytes. These samples go out in queue order on consecutive sample ticks. Padding words produce no output.
- R6: Releasing a data packet starts a burst. The burst ends with the last sample of a packet whose end-of-burst flag is set, even when that packet has only one sample.
- R7: `underrun_pulse` is high for one cycle after each sample tick that carried no sample while a burst was in progress. It never accompanies a sample.
- R8: `samp_valid` is high only in the cycle after a sample tick. After a sample tick that carries no sample, `samp_data` is zero.
- R9: A packet on channel 0x1F follows the same hold, release and discard rules. Its release tick carries no sample. Its payload words appear on `ctrl_data` with `ctrl_valid`, one per cycle, and `ctrl_last` marks the final word.
- R10: While reset is high and in the first cycle after it, `samp_valid`, `ctrl_valid`, `drop_pulse` and `underrun_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_tick | input | 1 | Converter sample enable; advances local time |
| q_data | input | DW | Word at the head of the packet queue |
| q_valid | input | 1 | Head word present |
| q_ready | output | 1 | Head word is consumed this cycle |
| samp_data | output | DW | Sample toward the converter (I in high half, Q in low half) |
| samp_valid | output | 1 | A payload sample is on samp_data |
| ctrl_data | output | DW | Control payload word |
| ctrl_valid | output | 1 | ctrl_data holds a word |
| ctrl_last | output | 1 | Final control word of the packet |
| drop_pulse | output | 1 | A late packet was discarded |
| underrun_pulse | output | 1 | A tick inside a burst carried no sample |

## Verification
Two functions can land in one tick cycle: releasing a packet and judging the underrun. A control packet released in the middle of a burst must still flag its tick as an underrun. A one-sample end-of-burst packet starts and ends its burst on the same edge, and the next idle tick must stay quiet. The bench generates both situations on purpose, alongside timestamps that arrive exactly on time, ahead of time, late, or wrapped. A tick-level reference model in the bench predicts the sample, the data value and the underrun flag for every tick.

// File: rtl/tsched_pkg.sv
package tsched_pkg;

  localparam logic [4:0]  CTRL_CHAN = 5'h1f;
  localparam logic [31:0] TS_NOW    = 32'hFFFF_FFFF;

  // header word, MSB first
  typedef struct packed {
    logic       ovr;
    logic       und;
    logic       drp;
    logic       sob;
    logic       eob;
    logic [5:0] rssi;
    logic [4:0] chan;
    logic [2:0] rsv;
    logic [3:0] tag;
    logic [8:0] len;
  } hdr_t;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_TS,
    ST_WAIT,
    ST_STREAM,
    ST_CTRL,
    ST_SKIP
  } sched_st_t;

endpackage

// File: rtl/tsched_timebase.sv
module tsched_timebase #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic [TW-1:0] now
);

  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else if (tick) now <= now + 1'b1;
  end

  p_time_step_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> now == $past(now) + 1'b1);

  p_time_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(now));

endmodule

// File: rtl/tsched_time_judge.sv
module tsched_time_judge #(
  parameter int TW = 32
) (
  input  logic [TW-1:0] now,
  input  logic [TW-1:0] ts,
  output logic          late,
  output logic          due
);

  logic              immediate;
  logic signed [TW-1:0] diff;

  always_comb begin
    immediate = (ts == {TW{1'b1}});
    diff      = $signed(now - ts);
    late      = !immediate && (diff > 0);
    due       = immediate || (now == ts);
  end

  always_comb begin
    p_late_vs_due_r3: assert (!(late && due));
  end

endmodule

// File: rtl/tsched_burst.sv
module tsched_burst (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic emit,
  input  logic enter,
  input  logic leave,
  output logic in_burst,
  output logic underrun_pulse
);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_burst       <= 1'b0;
      underrun_pulse <= 1'b0;
    end else begin
      underrun_pulse <= tick && !emit && in_burst;
      if (leave)      in_burst <= 1'b0;
      else if (enter) in_burst <= 1'b1;
    end
  end

  p_underrun_needs_burst_r7: assert property (@(posedge clk) disable iff (rst)
    underrun_pulse |-> $past(in_burst));

  p_leave_ends_burst_r6: assert property (@(posedge clk) disable iff (rst)
    leave |=> !in_burst);

endmodule

// File: rtl/tsched_tx.sv
module tsched_tx
  import tsched_pkg::*;
#(
  parameter int PKT_WORDS = 128,
  parameter int DW        = 32,
  parameter int TW        = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          samp_tick,
  input  logic [DW-1:0] q_data,
  input  logic          q_valid,
  output logic          q_ready,
  output logic [DW-1:0] samp_data,
  output logic          samp_valid,
  output logic [DW-1:0] ctrl_data,
  output logic          ctrl_valid,
  output logic          ctrl_last,
  output logic          drop_pulse,
  output logic          underrun_pulse
);

  localparam int MAX_PAY_WORDS = PKT_WORDS - 2;
  localparam int MAX_BYTES     = MAX_PAY_WORDS * 4;
  localparam int CW            = $clog2(PKT_WORDS + 1);
  localparam int BW            = (((CW + 2) > 9) ? (CW + 2) : 9) + 1;

  typedef logic [CW-1:0] cnt_t;
  typedef logic [BW-1:0] bytes_t;

  sched_st_t       st;
  hdr_t            hdr_q;
  logic [TW-1:0]   ts_q;
  cnt_t            rest;
  cnt_t            pay_left;

  logic [TW-1:0]   now;
  logic            late, due, go;
  logic            is_ctrl;
  bytes_t          clen;
  cnt_t            pay_words;
  logic            pop, emit, rel_data, leave;
  logic            in_burst;

  tsched_timebase #(.TW(TW)) u_time (
    .clk (clk),
    .rst (rst),
    .tick(samp_tick),
    .now (now)
  );

  tsched_time_judge #(.TW(TW)) u_judge (
    .now (now),
    .ts  (ts_q),
    .late(late),
    .due (due)
  );

  tsched_burst u_burst (
    .clk           (clk),
    .rst           (rst),
    .tick          (samp_tick),
    .emit          (emit),
    .enter         (rel_data),
    .leave         (leave),
    .in_burst      (in_burst),
    .underrun_pulse(underrun_pulse)
  );

  // payload size in words, length capped to what the packet can hold
  always_comb begin
    is_ctrl   = (hdr_q.chan == CTRL_CHAN);
    clen      = (bytes_t'(hdr_q.len) > bytes_t'(MAX_BYTES)) ? bytes_t'(MAX_BYTES)
                                                           : bytes_t'(hdr_q.len);
    pay_words = cnt_t'((clen + bytes_t'(3)) >> 2);
    go        = (st == ST_WAIT) && !late && due && samp_tick;
  end

  always_comb begin
    pop      = 1'b0;
    emit     = 1'b0;
    rel_data = 1'b0;
    leave    = 1'b0;
    unique case (st)
      ST_HDR, ST_TS, ST_CTRL, ST_SKIP: pop = q_valid;
      ST_WAIT: begin
        if (go && !is_ctrl) begin
          if (pay_words == '0) begin
            rel_data = 1'b1;
            leave    = hdr_q.eob;
          end else if (q_valid) begin
            pop      = 1'b1;
            emit     = 1'b1;
            rel_data = 1'b1;
            leave    = hdr_q.eob && (pay_words == cnt_t'(1));
          end
        end
      end
      ST_STREAM: begin
        if (samp_tick && q_valid) begin
          pop   = 1'b1;
          emit  = 1'b1;
          leave = hdr_q.eob && (pay_left == cnt_t'(1));
        end
      end
      default: ;
    endcase
  end

  assign q_ready = pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_HDR;
      hdr_q      <= '0;
      ts_q       <= '0;
      rest       <= '0;
      pay_left   <= '0;
      samp_data  <= '0;
      samp_valid <= 1'b0;
      ctrl_data  <= '0;
      ctrl_valid <= 1'b0;
      ctrl_last  <= 1'b0;
      drop_pulse <= 1'b0;
    end else begin
      samp_valid <= 1'b0;
      ctrl_valid <= 1'b0;
      ctrl_last  <= 1'b0;
      drop_pulse <= 1'b0;

      if (samp_tick) begin
        samp_valid <= emit;
        samp_data  <= emit ? q_data : '0;
      end

      unique case (st)
        ST_HDR: begin
          if (q_valid) begin
            hdr_q <= hdr_t'(q_data[31:0]);
            st    <= ST_TS;
          end
        end
        ST_TS: begin
          if (q_valid) begin
            ts_q <= q_data[TW-1:0];
            rest <= cnt_t'(MAX_PAY_WORDS);
            st   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (late) begin
            drop_pulse <= 1'b1;
            st         <= ST_SKIP;
          end else if (go) begin
            if (is_ctrl) begin
              pay_left <= pay_words;
              st       <= (pay_words == '0) ? ST_SKIP : ST_CTRL;
            end else if (pay_words == '0) begin
              st <= ST_SKIP;
            end else if (q_valid) begin
              rest     <= rest - 1'b1;
              pay_left <= pay_words - 1'b1;
              if (pay_words == cnt_t'(1))
                st <= (rest == cnt_t'(1)) ? ST_HDR : ST_SKIP;
              else
                st <= ST_STREAM;
            end
          end
        end
        ST_STREAM: begin
          if (samp_tick && q_valid) begin
            rest     <= rest - 1'b1;
            pay_left <= pay_left - 1'b1;
            if (pay_left == cnt_t'(1))
              st <= (rest == cnt_t'(1)) ? ST_HDR : ST_SKIP;
          end
        end
        ST_CTRL: begin
          if (q_valid) begin
            ctrl_valid <= 1'b1;
            ctrl_data  <= q_data;
            ctrl_last  <= (pay_left == cnt_t'(1));
            rest       <= rest - 1'b1;
            pay_left   <= pay_left - 1'b1;
            if (pay_left == cnt_t'(1))
              st <= (rest == cnt_t'(1)) ? ST_HDR : ST_SKIP;
          end
        end
        ST_SKIP: begin
          if (q_valid) begin
            rest <= rest - 1'b1;
            if (rest == cnt_t'(1)) st <= ST_HDR;
          end
        end
        default: st <= ST_HDR;
      endcase
    end
  end

  p_sample_after_tick_r8: assert property (@(posedge clk) disable iff (rst)
    samp_valid |-> $past(samp_tick));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(samp_tick) && !samp_valid) |-> samp_data == '0);

  p_drop_single_r3: assert property (@(posedge clk) disable iff (rst)
    drop_pulse |=> !drop_pulse);

  p_ctrl_no_sample_r9: assert property (@(posedge clk) disable iff (rst)
    ctrl_valid |-> !samp_valid);

  p_no_underrun_with_sample_r7: assert property (@(posedge clk) disable iff (rst)
    !(samp_valid && underrun_pulse));

endmodule

// File: tb/tsched_tx_test.sv
module tsched_tx_test;

  localparam int PW    = 16;
  localparam int MAXPW = PW - 2;
  localparam int NPKT  = 48;
  localparam int NW    = NPKT * PW;
  localparam int MAXT  = 1200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        samp_tick = 1'b0;
  logic [31:0] q_data;
  logic        q_valid;
  logic        q_ready;
  logic [31:0] samp_data;
  logic        samp_valid;
  logic [31:0] ctrl_data;
  logic        ctrl_valid;
  logic        ctrl_last;
  logic        drop_pulse;
  logic        underrun_pulse;

  always #5 clk = ~clk;

  tsched_tx #(.PKT_WORDS(PW), .DW(32), .TW(32)) uut (
    .clk(clk), .rst(rst), .samp_tick(samp_tick),
    .q_data(q_data), .q_valid(q_valid), .q_ready(q_ready),
    .samp_data(samp_data), .samp_valid(samp_valid),
    .ctrl_data(ctrl_data), .ctrl_valid(ctrl_valid), .ctrl_last(ctrl_last),
    .drop_pulse(drop_pulse), .underrun_pulse(underrun_pulse)
  );

  // queue image and expected results
  logic [31:0] mem [NW];
  int          total = 0;
  int          rd = 0;
  logic        started = 1'b0;

  logic        exp_v [MAXT];
  logic [31:0] exp_d [MAXT];
  logic        exp_u [MAXT];
  string       exp_tag [MAXT];
  logic [31:0] exp_cw [NW];
  logic        exp_cl [NW];
  int          ncw = 0;
  int          exp_drops = 0;

  logic [31:0] t_model = 0;
  bit          inb = 0;
  bit          prev_late = 0;

  int nchk = 0;
  int nerr = 0;
  int ndrop = 0;
  int cidx = 0;

  assign q_valid = started && (rd < total);
  assign q_data  = (rd < total) ? mem[rd] : 32'h0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic idle_tick(input int k);
    exp_v[k]   = 1'b0;
    exp_d[k]   = 32'h0;
    exp_u[k]   = inb;
    exp_tag[k] = inb ? "R7" : "R6 R8";
  endtask

  // builds one packet into the queue image and advances the tick-level model
  task automatic add_pkt(input bit s, input bit e, input logic [4:0] ch,
                         input logic [8:0] len, input logic [31:0] ts);
    int base;
    int nwd;
    int clen;
    logic [31:0] start;
    bit late;
    base = total;
    mem[base]     = {3'b000, s, e, 6'd0, ch, 3'd0, 4'd0, len};
    mem[base + 1] = ts;
    for (int i = 0; i < MAXPW; i++) mem[base + 2 + i] = $urandom;
    total += PW;
    late = (ts != 32'hFFFF_FFFF) && ($signed(t_model - ts) > 0);
    prev_late = late;
    if (late) begin
      exp_drops++;
      return;
    end
    start = (ts == 32'hFFFF_FFFF) ? t_model : ts;
    for (int k = int'(t_model); k < int'(start); k++) idle_tick(k);
    clen = (int'(len) > MAXPW * 4) ? MAXPW * 4 : int'(len);
    nwd  = (clen + 3) / 4;
    if (ch == 5'h1f) begin
      idle_tick(int'(start));
      exp_tag[int'(start)] = inb ? "R9 R7" : "R9";
      for (int i = 0; i < nwd; i++) begin
        exp_cw[ncw] = mem[base + 2 + i];
        exp_cl[ncw] = (i == nwd - 1);
        ncw++;
      end
      t_model = start + 1;
    end else begin
      inb = 1;
      for (int i = 0; i < nwd; i++) begin
        exp_v[int'(start) + i] = 1'b1;
        exp_d[int'(start) + i] = mem[base + 2 + i];
        exp_u[int'(start) + i] = 1'b0;
        exp_tag[int'(start) + i] = (i != 0) ? "R1 R5" :
                                   (ts == 32'hFFFF_FFFF) ? "R4" : "R2";
      end
      if (e) inb = 0;
      t_model = start + 32'(nwd);
    end
  endtask

  task automatic build();
    void'($urandom(32'd20240611));
    add_pkt(1, 0, 5'd0, 9'd12, 32'hFFFF_FFFF);     // R4 immediate, 3 samples
    add_pkt(0, 1, 5'd0, 9'd9, t_model + 2);         // gap inside burst: R7
    add_pkt(1, 1, 5'd0, 9'd4, t_model + 2);         // gap outside burst, 1-sample burst R6
    add_pkt(1, 0, 5'd0, 9'd8, t_model - 1);         // late R3
    add_pkt(0, 0, 5'h1f, 9'd10, t_model + 1);       // control R9
    add_pkt(1, 0, 5'd0, 9'd8, t_model + 32'h9000_0000); // wrap-late R3
    add_pkt(1, 0, 5'd3, 9'd504, 32'hFFFF_FFFF);     // capped length R5
    add_pkt(0, 1, 5'd3, 9'd7, t_model);             // exactly on time, back to back
    add_pkt(1, 0, 5'd1, 9'd8, 32'hFFFF_FFFF);
    add_pkt(0, 0, 5'h1f, 9'd4, t_model);            // control inside burst R9 R7
    add_pkt(0, 1, 5'd1, 9'd8, t_model);
    for (int p = 11; p < NPKT; p++) begin
      int kind;
      logic [8:0] ln;
      bit e;
      kind = int'($urandom % 10);
      ln   = 9'(1 + ($urandom % 60));
      e    = ($urandom % 3) == 0;
      if (kind < 2 && !prev_late) begin
        if (t_model >= 3) add_pkt(!inb, e, 5'd2, ln, t_model - 32'(1 + ($urandom % 3)));
        else              add_pkt(!inb, e, 5'd2, ln, t_model + 32'h9000_0000);
      end else if (kind == 2) begin
        add_pkt(0, 0, 5'h1f, ln, t_model + 32'($urandom % 3));
      end else if (kind == 3) begin
        add_pkt(!inb, e, 5'(kind), ln, 32'hFFFF_FFFF);
      end else begin
        add_pkt(!inb, e, 5'($urandom % 31), ln, t_model + 32'($urandom % 3));
      end
    end
    for (int k = int'(t_model); k < int'(t_model) + 4; k++) idle_tick(k);
  endtask

  // queue pop
  initial begin
    forever begin
      @(posedge clk);
      if (q_ready && q_valid) rd <= rd + 1;
    end
  end

  // control port monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && ctrl_valid) begin
        if (cidx < ncw) begin
          chk(ctrl_data == exp_cw[cidx], "R9 data", ctrl_data, exp_cw[cidx]);
          chk(ctrl_last == exp_cl[cidx], "R9 last", 32'(ctrl_last), 32'(exp_cl[cidx]));
        end else begin
          chk(1'b0, "R9 extra word", ctrl_data, 32'h0);
        end
        cidx++;
      end
      if (!rst && drop_pulse) ndrop++;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int nt;
    build();
    nt = int'(t_model) + 4;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!samp_valid && !ctrl_valid && !drop_pulse && !underrun_pulse, "R10 during reset",
        {28'h0, samp_valid, ctrl_valid, drop_pulse, underrun_pulse}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!samp_valid && !ctrl_valid && !drop_pulse && !underrun_pulse, "R10 after reset",
        {28'h0, samp_valid, ctrl_valid, drop_pulse, underrun_pulse}, 32'h0);
    started = 1'b1;
    repeat (39) @(negedge clk);
    for (int k = 0; k < nt; k++) begin
      samp_tick = 1'b1;
      @(negedge clk);
      samp_tick = 1'b0;
      chk(samp_valid == exp_v[k], exp_tag[k], 32'(samp_valid), 32'(exp_v[k]));
      chk(samp_data == exp_d[k], exp_v[k] ? exp_tag[k] : "R8", samp_data, exp_d[k]);
      chk(underrun_pulse == exp_u[k], "R6 R7", 32'(underrun_pulse), 32'(exp_u[k]));
      repeat (38) @(negedge clk);
    end
    chk(ndrop == exp_drops, "R3 drop count", 32'(ndrop), 32'(exp_drops));
    chk(cidx == ncw, "R9 control word count", 32'(cidx), 32'(ncw));
    chk(rd == total, "R1 words consumed", 32'(rd), 32'(total));
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule